// File: doc/BRIEF.md
# Jittered Fractional Baud Generator

This block produces the bit timing for a serial frame from a fast master clock. A shared integer divisor sets how many clocks one oversample unit lasts, and a nominal bit is sixteen of those units. Each bit position of a frame can also carry a two-bit adjust code. The code stretches that one bit by one unit or trims it by one unit. Spread over a frame, these single-bit corrections cancel most of the drift that the integer divisor would otherwise build up.

There are two identical timing channels, one for transmit and one for receive. They share the divisor, but each has its own adjust word and its own frame-start pulse. A channel waits idle until its first start pulse. On that pulse it captures the divisor, its adjust word and the frame length. It then emits an oversample tick once per unit, and a bit-end strobe on the last unit of every bit, while it counts the bit position. It keeps running with nominal bits past the end of the frame until the next start pulse.

Top module: `frac_baud_gen`

## Requirements
- R1: With adjust code 0, bit p ends exactly (DIV+1)*16 clocks after bit p-1 ended. Bit 0 ends (DIV+1)*16 clocks after the clock edge that captured the start pulse.
- R2: Bit position n takes its code from adjust bits [2n+1:2n]. Code 1 makes the bit (DIV+1)*17 clocks long, and code 3 makes it (DIV+1)*15 clocks long.
- R3: Code 2 has the same effect as code 0: a bit of (DIV+1)*16 clocks.
- R4: The tick is a one-clock pulse every DIV+1 clocks while a channel runs. A bit holds 16, 17 or 15 ticks for codes 0/2, 1 and 3, and the bit-end strobe coincides with the last tick of the bit.
- R5: The bit index reads 0 through the first bit of a frame and rises by one after each bit end. It saturates at 15.
- R6: Bit positions at or beyond the captured frame length (0 to 15) use code 0 whatever the adjust word holds there, and the channel keeps producing nominal bits.
- R7: Divisor, adjust word and frame length are captured only on a start pulse. Changes between start pulses do not alter the running frame.
- R8: The transmit and receive channels time independently, each from its own start pulse and adjust word, and both use the shared divisor.
- R9: A start pulse during a running frame restarts the channel at position 0 with a full first bit.
- R10: After reset, and until a channel's first start pulse, that channel gives no tick and no bit-end, and its index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | Divisor; one unit is div_i+1 clocks |
| frame_len_i | input | IDX_W | Number of bit positions that use the adjust word |
| tx_start_i | input | 1 | Transmit frame-start pulse |
| tx_adj_i | input | 2*MAX_BITS | Transmit adjust word, two bits per position |
| rx_start_i | input | 1 | Receive frame-start pulse |
| rx_adj_i | input | 2*MAX_BITS | Receive adjust word, two bits per position |
| tx_tick_o | output | 1 | Transmit oversample tick |
| tx_bit_end_o | output | 1 | Transmit bit-end strobe |
| tx_bit_idx_o | output | IDX_W | Transmit bit position |
| rx_tick_o | output | 1 | Receive oversample tick |
| rx_bit_end_o | output | 1 | Receive bit-end strobe |
| rx_bit_idx_o | output | IDX_W | Receive bit position |

## Verification
Ticks and strobes are decoded combinationally from registered counters, so every result shows up as a count of clocks since the edge that captured the start pulse. The first tick is due DIV+1 clocks after that edge, and bit p ends at the running sum of its predecessors' widths. The bench drives and samples on the falling edge and numbers each falling edge after the start edge. It records the number at every bit end and compares the differences with widths it computes from the divisor and the adjust codes. At the same points it checks the tick count within each bit and the index value.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    // Per-bit adjust code, two bits per frame position
    typedef enum logic [1:0] {
        ADJ_KEEP   = 2'd0,
        ADJ_WIDEN  = 2'd1,
        ADJ_INERT  = 2'd2,
        ADJ_NARROW = 2'd3
    } adj_code_e;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

    localparam int UNITS_NOMINAL = 16;
    localparam int UNIT_W        = 5;

    // Index of the final oversample unit of a bit for a given code
    function automatic logic [UNIT_W-1:0] last_unit(adj_code_e code);
        case (code)
            ADJ_WIDEN:  last_unit = UNIT_W'(UNITS_NOMINAL);
            ADJ_NARROW: last_unit = UNIT_W'(UNITS_NOMINAL - 2);
            default:    last_unit = UNIT_W'(UNITS_NOMINAL - 1);
        endcase
    endfunction

endpackage

// File: rtl/fbg_adj_select.sv
module fbg_adj_select
    import fbg_pkg::*;
#(
    parameter int MAX_BITS = 12,
    parameter int IDX_W    = 4,
    parameter int ADJ_W    = 2 * MAX_BITS
) (
    input  logic [ADJ_W-1:0] adj_i,
    input  logic [IDX_W-1:0] len_i,
    input  logic [IDX_W-1:0] pos_i,
    output adj_code_e        code_o
);

    // Positions outside the frame, or beyond the word, fall back to KEEP
    always_comb begin
        code_o = ADJ_KEEP;
        for (int i = 0; i < MAX_BITS; i++) begin
            if ((pos_i == IDX_W'(i)) && (IDX_W'(i) < len_i)) begin
                code_o = adj_code_e'(adj_i[2*i +: 2]);
            end
        end
    end

endmodule

// File: rtl/fbg_sub_counter.sv
module fbg_sub_counter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt;

    assign tick_o = run_i && (cnt == div_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart_i) begin
            cnt <= '0;
        end else if (run_i) begin
            cnt <= tick_o ? '0 : cnt + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (run_i && !restart_i && tick_o && (div_i != '0)) |=> !tick_o); // R4

endmodule

// File: rtl/fbg_channel.sv
module fbg_channel
    import fbg_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int MAX_BITS = 12,
    parameter int IDX_W    = 4,
    parameter int ADJ_W    = 2 * MAX_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [IDX_W-1:0] frame_len_i,
    input  logic [ADJ_W-1:0] adj_i,
    output logic             tick_o,
    output logic             bit_end_o,
    output logic [IDX_W-1:0] bit_idx_o
);

    gen_state_e        state;
    logic [DIV_W-1:0]  div_l;
    logic [ADJ_W-1:0]  adj_l;
    logic [IDX_W-1:0]  len_l;
    logic [UNIT_W-1:0] unit;
    logic [IDX_W-1:0]  pos;
    logic [UNIT_W-1:0] unit_last;
    adj_code_e         code;
    logic              running;
    logic              tick;

    assign running = (state == GEN_RUN);

    fbg_sub_counter #(.DIV_W(DIV_W)) u_sub (
        .clk       (clk),
        .rst       (rst),
        .restart_i (start_i),
        .run_i     (running),
        .div_i     (div_l),
        .tick_o    (tick)
    );

    fbg_adj_select #(
        .MAX_BITS (MAX_BITS),
        .IDX_W    (IDX_W),
        .ADJ_W    (ADJ_W)
    ) u_sel (
        .adj_i  (adj_l),
        .len_i  (len_l),
        .pos_i  (pos),
        .code_o (code)
    );

    assign unit_last = last_unit(code);
    assign tick_o    = tick;
    assign bit_end_o = tick && (unit == unit_last);
    assign bit_idx_o = pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GEN_IDLE;
            div_l <= '0;
            adj_l <= '0;
            len_l <= '0;
            unit  <= '0;
            pos   <= '0;
        end else if (start_i) begin
            state <= GEN_RUN;
            div_l <= div_i;
            adj_l <= adj_i;
            len_l <= frame_len_i;
            unit  <= '0;
            pos   <= '0;
        end else if (running && tick) begin
            if (unit == unit_last) begin
                unit <= '0;
                if (pos != {IDX_W{1'b1}}) pos <= pos + 1'b1;
            end else begin
                unit <= unit + 1'b1;
            end
        end
    end

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!tick_o && pos == '0)); // R10
    AST_RESTART_POS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (pos == '0 && unit == '0)); // R9
    AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
        (running && bit_end_o && !start_i && pos != {IDX_W{1'b1}})
        |=> (pos == IDX_W'($past(pos) + 1'b1))); // R5
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (running && !start_i) |=> ($stable(div_l) && $stable(adj_l) && $stable(len_l))); // R7
    AST_UNIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        running |-> (unit <= UNIT_W'(UNITS_NOMINAL))); // R2

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int MAX_BITS = 12,
    parameter int IDX_W    = $clog2(MAX_BITS + 1),
    parameter int ADJ_W    = 2 * MAX_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic [IDX_W-1:0] frame_len_i,
    input  logic             tx_start_i,
    input  logic [ADJ_W-1:0] tx_adj_i,
    input  logic             rx_start_i,
    input  logic [ADJ_W-1:0] rx_adj_i,
    output logic             tx_tick_o,
    output logic             tx_bit_end_o,
    output logic [IDX_W-1:0] tx_bit_idx_o,
    output logic             rx_tick_o,
    output logic             rx_bit_end_o,
    output logic [IDX_W-1:0] rx_bit_idx_o
);

    localparam int N_CH = 2;

    logic [N_CH-1:0]            start_v;
    logic [N_CH-1:0][ADJ_W-1:0] adj_v;
    logic [N_CH-1:0]            tick_v;
    logic [N_CH-1:0]            end_v;
    logic [N_CH-1:0][IDX_W-1:0] idx_v;

    assign start_v = {rx_start_i, tx_start_i};
    assign adj_v   = {rx_adj_i, tx_adj_i};

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        fbg_channel #(
            .DIV_W    (DIV_W),
            .MAX_BITS (MAX_BITS),
            .IDX_W    (IDX_W),
            .ADJ_W    (ADJ_W)
        ) u_chan (
            .clk         (clk),
            .rst         (rst),
            .start_i     (start_v[ch]),
            .div_i       (div_i),
            .frame_len_i (frame_len_i),
            .adj_i       (adj_v[ch]),
            .tick_o      (tick_v[ch]),
            .bit_end_o   (end_v[ch]),
            .bit_idx_o   (idx_v[ch])
        );
    end

    assign tx_tick_o    = tick_v[0];
    assign tx_bit_end_o = end_v[0];
    assign tx_bit_idx_o = idx_v[0];
    assign rx_tick_o    = tick_v[1];
    assign rx_bit_end_o = end_v[1];
    assign rx_bit_idx_o = idx_v[1];

    AST_END_WITH_TICK: assert property (@(posedge clk) disable iff (rst)
        (tx_bit_end_o |-> tx_tick_o) and (rx_bit_end_o |-> rx_tick_o)); // R4

endmodule

// File: tb/tb_frac_baud_gen.sv
`timescale 1ns/1ps
module tb_frac_baud_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  div = '0;
    logic [3:0]  flen = '0;
    logic        tx_start = 1'b0;
    logic        rx_start = 1'b0;
    logic [23:0] tx_adj = '0;
    logic [23:0] rx_adj = '0;
    logic        tx_tick, tx_end, rx_tick, rx_end;
    logic [3:0]  tx_idx, rx_idx;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    int ends    [2][32];
    int ticks_in[2][32];
    int idx_at  [2][32];
    int nends   [2];
    int tick_acc[2];

    always #5 clk = ~clk;

    frac_baud_gen dut (
        .clk(clk), .rst(rst), .div_i(div), .frame_len_i(flen),
        .tx_start_i(tx_start), .tx_adj_i(tx_adj),
        .rx_start_i(rx_start), .rx_adj_i(rx_adj),
        .tx_tick_o(tx_tick), .tx_bit_end_o(tx_end), .tx_bit_idx_o(tx_idx),
        .rx_tick_o(rx_tick), .rx_bit_end_o(rx_end), .rx_bit_idx_o(rx_idx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int units(input int code);
        case (code)
            1: return 17;
            3: return 15;
            default: return 16;
        endcase
    endfunction

    function automatic int exp_width(input int d, input logic [23:0] a, input int len, input int p);
        int code;
        code = (p < len && p < 12) ? int'(a[2*p +: 2]) : 0;
        return (d + 1) * units(code);
    endfunction

    // Count falling edges after the start edge; record bit ends per channel
    task automatic measure(input int ncyc);
        for (int c = 0; c < 2; c++) begin
            nends[c] = 0;
            tick_acc[c] = 0;
        end
        for (int n = 1; n <= ncyc; n++) begin
            @(negedge clk);
            tx_start = 1'b0;
            rx_start = 1'b0;
            for (int c = 0; c < 2; c++) begin
                logic tk, be;
                logic [3:0] ix;
                tk = c ? rx_tick : tx_tick;
                be = c ? rx_end : tx_end;
                ix = c ? rx_idx : tx_idx;
                if (tk) tick_acc[c]++;
                if (be && nends[c] < 32) begin
                    ends[c][nends[c]]     = n;
                    ticks_in[c][nends[c]] = tick_acc[c];
                    idx_at[c][nends[c]]   = int'(ix);
                    tick_acc[c] = 0;
                    nends[c]++;
                end
            end
        end
    endtask

    task automatic check_bits(input int c, input int d, input logic [23:0] a,
                              input int len, input int nb, input string req);
        check(nends[c] >= nb, {req, " bit count"}, nends[c], nb);
        for (int p = 0; p < nb && p < nends[c]; p++) begin
            int w, ew;
            w  = ends[c][p] - ((p == 0) ? 0 : ends[c][p-1]);
            ew = exp_width(d, a, len, p);
            check(w == ew, {req, " width"}, w, ew);
            check(ticks_in[c][p] == ew / (d + 1), {req, " R4 ticks"}, ticks_in[c][p], ew / (d + 1));
            check(idx_at[c][p] == ((p > 15) ? 15 : p), {req, " R5 index"}, idx_at[c][p], (p > 15) ? 15 : p);
        end
    endtask

    task automatic pulse(input bit t, input bit r);
        @(negedge clk);
        tx_start = t;
        rx_start = r;
    endtask

    task automatic t_reset();
        int seen;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tx_tick || tx_end || rx_tick || rx_end || tx_idx != 0 || rx_idx != 0) seen++;
        end
        check(seen == 0, "R10 idle after reset", seen, 0);
    endtask

    task automatic t_nominal();
        div = 8'd3; flen = 4'd10; tx_adj = '0;
        pulse(1, 0);
        measure(10 * 64 + 4);
        check_bits(0, 3, 24'h0, 10, 10, "R1");
    endtask

    task automatic t_mix();
        logic [23:0] a;
        int codes[12] = '{1, 3, 2, 0, 1, 1, 3, 3, 2, 0, 1, 3};
        a = '0;
        for (int p = 0; p < 12; p++) a[2*p +: 2] = 2'(codes[p]);
        div = 8'd3; flen = 4'd12; tx_adj = a;
        pulse(1, 0);
        measure(12 * 68 + 4);
        check_bits(0, 3, a, 12, 12, "R2 R3");
    endtask

    task automatic t_div0();
        logic [23:0] a;
        a = 24'h0000_F4; // pos0 keep, pos1 widen, pos2 narrow, pos3 narrow
        div = 8'd0; flen = 4'd4; rx_adj = a;
        pulse(0, 1);
        measure(80);
        check_bits(1, 0, a, 4, 4, "R2 div0");
    endtask

    task automatic t_beyond();
        div = 8'd0; flen = 4'd3; tx_adj = 24'h555555;
        pulse(1, 0);
        measure(300);
        check_bits(0, 0, 24'h555555, 3, 18, "R6");
    endtask

    task automatic t_midframe();
        div = 8'd2; flen = 4'd3; tx_adj = 24'h555555;
        pulse(1, 0);
        fork
            measure(200);
            begin
                repeat (20) @(negedge clk);
                div = 8'd6; tx_adj = 24'h0; flen = 4'd9;
            end
        join
        check_bits(0, 2, 24'h555555, 3, 3, "R7 held");
        pulse(1, 0);
        measure(120);
        check_bits(0, 6, 24'h0, 9, 1, "R7 new");
    endtask

    task automatic t_indep();
        div = 8'd2; flen = 4'd4; tx_adj = 24'h555555; rx_adj = 24'hFFFFFF;
        pulse(1, 1);
        measure(4 * 51 + 5);
        check_bits(0, 2, 24'h555555, 4, 4, "R8 tx");
        check_bits(1, 2, 24'hFFFFFF, 4, 4, "R8 rx");
    endtask

    task automatic t_restart();
        div = 8'd1; flen = 4'd10; tx_adj = '0;
        pulse(1, 0);
        measure(50);
        pulse(1, 0);
        measure(70);
        check_bits(0, 1, 24'h0, 10, 2, "R9");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_nominal();
        t_mix();
        t_div0();
        t_beyond();
        t_midframe();
        t_indep();
        t_restart();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule